// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block carries 9-bit words from a write clock domain to an unrelated read clock domain. Both pointers cross the domain boundary as Gray code through two-flop synchronisers, so every flag is conservative. The flags may report less data, or less free space, than is really present, but never more.

A mode input is sampled while reset is held. In standard mode a word is fetched into the output register on a read request, and `rd_empty` reports an empty queue. In first-word-fall-through mode the oldest word is loaded into the output register without any request. `rd_empty` then means "output not ready", and `rd_en` consumes the word on display. The output register adds one word of storage in this mode.

The write side reports full ("not ready" in fall-through mode), half-full and almost-full. The read side reports almost-empty. A retransmit strobe on the read side rewinds the read pointer to the first word written after the last reset, so that data can be replayed. Output enable gates the data bus to zero and drops a drive-indicator bit.

Top module: `dc_fifo_rt`

## Requirements
- R1: The mode is taken from `fwft_mode` while each domain's reset is low (0 = standard, 1 = fall-through). Later changes of `fwft_mode` have no effect until the next reset.
- R2: One cycle after reset: `rd_empty`=1, `wr_full`=0, `almost_empty`=1, `almost_full`=0, `half_full`=0 and `rd_data`=0.
- R3: In standard mode, words come out in write order. A read request loads the next word into `rd_data` on the read edge that samples it. A read request while `rd_empty` is high changes nothing.
- R4: `wr_full` is high when storage holds 2^AW words (16 by default). Writes while it is high are dropped, so standard mode holds at most 2^AW words.
- R5: In fall-through mode, the oldest word appears on `rd_data` with `rd_empty` low and no request. `rd_en` consumes it. Up to 2^AW+1 words can be held.
- R6: `almost_empty` is high when the number of readable words is at most `ae_offset`. In fall-through mode the readable count includes the word in the output register.
- R7: `almost_full` is high when the stored words are at least 2^AW − `af_offset`. `half_full` is high when the stored words exceed 2^(AW−1). The stored count excludes the fall-through output register.
- R8: `retx` rewinds reading to the first word written after reset. In standard mode `rd_empty` is high in the cycle after the strobe and low in the next, and the next read returns that first word.
- R9: In fall-through mode, after `retx` the output stays not-ready for two read cycles, and then shows the first word written after reset.
- R10: After a retransmit, `almost_empty` and `half_full` reflect the rewound read pointer.
- R11: While `rd_oe` is low, `rd_data` is 0 and `rd_drv` is 0. The queue contents and pointers are not disturbed.
- R12: A single write into an empty standard-mode FIFO clears `rd_empty` after exactly two read-clock edges, because the write pointer passes through two synchroniser flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DW (9) | Write data |
| af_offset | input | AW (4) | Almost-full distance from full |
| wr_full | output | 1 | Full (fall-through: input not ready) |
| almost_full | output | 1 | Almost-full flag |
| half_full | output | 1 | More than half of storage used |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| fwft_mode | input | 1 | Mode select, sampled in reset |
| rd_en | input | 1 | Read request / consume |
| rd_oe | input | 1 | Output enable |
| retx | input | 1 | Retransmit strobe |
| ae_offset | input | AW (4) | Almost-empty distance from empty |
| rd_data | output | DW (9) | Read data, zero when disabled |
| rd_drv | output | 1 | High while the data bus is driven |
| rd_empty | output | 1 | Empty (fall-through: output not ready) |
| almost_empty | output | 1 | Almost-empty flag |

## Verification
A write becomes visible on the read side after two read edges. A read or rewind becomes visible on the write side after two write edges. The bench therefore waits eight read cycles after each burst before it checks any flag. Standard read data is due on the read edge that samples `rd_en`. Fall-through data is due at once and is replaced on the consuming edge. The bench drives every input at a falling edge and samples at the next falling edge. The retransmit checks fall on the first, second and third falling edges after the strobe, which separates the one-cycle standard setup from the two-cycle fall-through setup. The synchroniser delay itself is checked by counting read edges until `rd_empty` drops.

// File: rtl/dcf_pkg.sv
// Shared types for the dual-clock retransmit FIFO.
package dcf_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dcf_sync2.sv
// Two-flop synchroniser for a Gray-coded pointer.
// Assumes the input changes by at most one bit per source clock.
module dcf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the foreign pointer through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
// Storage array: write port in the write domain, asynchronous read port.
// Assumes the read side only addresses words already written.
module dcf_ram #(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Store one word per accepted write
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-side control: write pointer, full / almost-full / half-full flags.
// Assumes rgray_sync is the synchronised Gray read pointer (RAM words taken).
module dcf_wr_ctl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    input  logic [AW-1:0] af_offset,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          push,
    output logic          wr_full,
    output logic          almost_full,
    output logic          half_full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin;
    logic [PW-1:0] level;
    logic [PW-1:0] wbin_inc;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Occupancy seen from the write side and the derived flags
    always_comb begin
        rbin        = g2b(rgray_sync);
        level       = wbin - rbin;
        wr_full     = (level == PW'(DEPTH));
        push        = wr_en && !wr_full;
        wbin_inc    = wbin + 1'b1;
        almost_full = (level >= (PW'(DEPTH) - {1'b0, af_offset}));
        half_full   = (level > PW'(DEPTH / 2));
        waddr       = wbin[AW-1:0];
    end

    // Advance the binary and Gray write pointers on each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin_inc;
            wgray <= wbin_inc ^ (wbin_inc >> 1);
        end
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && wr_en) |=> (wbin == $past(wbin)));

    a_r4_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-side control: read pointer, output register, mode, retransmit and
// almost-empty flag. Assumes wgray_sync is the synchronised Gray write pointer
// and that retransmit is used before the write pointer wraps.
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_in,
    input  logic          rd_en,
    input  logic          retx,
    input  logic [AW-1:0] ae_offset,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] q,
    output logic          rd_empty,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    fifo_mode_e    mode_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] wbin;
    logic [PW-1:0] ram_cnt;
    logic [PW-1:0] level;
    logic          ram_empty;
    logic          fwft;
    logic          ov;
    logic          busy;
    logic          take;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Decide whether a word leaves the RAM this cycle, and derive the flags
    always_comb begin
        fwft      = (mode_q == MODE_FWFT);
        wbin      = g2b(wgray_sync);
        ram_cnt   = wbin - rbin;
        ram_empty = (ram_cnt == '0);
        if (fwft) take = !ram_empty && !busy && (!ov || rd_en);
        else      take = rd_en && !ram_empty && !busy;
        rd_empty     = fwft ? !ov : (ram_empty || busy);
        level        = ram_cnt + {{AW{1'b0}}, (fwft && ov)};
        almost_empty = (level <= {1'b0, ae_offset});
        raddr        = rbin[AW-1:0];
        if (retx)      rbin_nxt = '0;
        else if (take) rbin_nxt = rbin + 1'b1;
        else           rbin_nxt = rbin;
    end

    // Pointer, output register and retransmit setup state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= fifo_mode_e'(mode_in);
            rbin   <= '0;
            rgray  <= '0;
            q      <= '0;
            ov     <= 1'b0;
            busy   <= 1'b0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
            busy  <= retx;
            if (retx) begin
                ov <= 1'b0;
            end else if (take) begin
                q  <= ram_rdata;
                ov <= 1'b1;
            end else if (fwft && rd_en && ov) begin
                ov <= 1'b0;
            end
        end
    end

    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && rd_empty && rd_en && !retx) |=> $stable(rbin));

    a_r8_retx_hides_output: assert property (@(posedge clk) disable iff (!rst_n)
        retx |=> rd_empty);

    a_r5_fwft_holds_word: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && !rd_empty && !rd_en && !retx) |=> (!rd_empty && $stable(q)));

    a_r5_fwft_autofill: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && rd_empty && !ram_empty && !busy && !retx) |=> !rd_empty);
endmodule

// File: rtl/dc_fifo_rt.sv
// Dual-clock FIFO with retransmit and standard / fall-through modes.
// Assumes both resets are applied together and that at most 2^AW-2 words
// are written between reset and a retransmit.
module dc_fifo_rt #(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] af_offset,
    output logic          wr_full,
    output logic          almost_full,
    output logic          half_full,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          fwft_mode,
    input  logic          rd_en,
    input  logic          rd_oe,
    input  logic          retx,
    input  logic [AW-1:0] ae_offset,
    output logic [DW-1:0] rd_data,
    output logic          rd_drv,
    output logic          rd_empty,
    output logic          almost_empty
);
    logic [AW:0]   wgray, wgray_rs;
    logic [AW:0]   rgray, rgray_ws;
    logic [AW-1:0] waddr, raddr;
    logic          push;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] q;

    dcf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_sync(rgray_ws),
        .af_offset(af_offset), .wgray(wgray), .waddr(waddr), .push(push),
        .wr_full(wr_full), .almost_full(almost_full), .half_full(half_full)
    );

    dcf_sync2 #(.W(AW + 1)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rs)
    );

    dcf_sync2 #(.W(AW + 1)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_ws)
    );

    dcf_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(ram_rdata)
    );

    dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .mode_in(fwft_mode), .rd_en(rd_en),
        .retx(retx), .ae_offset(ae_offset), .wgray_sync(wgray_rs),
        .ram_rdata(ram_rdata), .raddr(raddr), .rgray(rgray), .q(q),
        .rd_empty(rd_empty), .almost_empty(almost_empty)
    );

    // Output gating: bus modelled as zero plus a drive bit while disabled (R11)
    assign rd_data = rd_oe ? q : '0;
    assign rd_drv  = rd_oe;
endmodule

// File: tb/test_dc_fifo_rt.sv
`timescale 1ns/1ps
module test_dc_fifo_rt;
    localparam int DW = 9;
    localparam int AW = 4;

    typedef struct packed {
        logic       fw;
        logic [5:0] cnt;
        logic [8:0] seed;
        logic [5:0] nread;
        logic       full;
        logic       half;
        logic       af;
        logic       ae;
    } vec_t;

    // mode, words written, first value, words readable, expected flags
    localparam vec_t VECS [7] = '{
        '{1'b0, 6'd1,  9'h011, 6'd1,  1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 6'd9,  9'h0A0, 6'd9,  1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 6'd16, 9'h1F0, 6'd16, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b0, 6'd17, 9'h055, 6'd16, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 6'd16, 9'h123, 6'd16, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 6'd17, 9'h0F7, 6'd17, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 6'd2,  9'h1C0, 6'd2,  1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n, rd_rst_n, wr_en, rd_en, rd_oe, retx, fwft_mode;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] af_offset, ae_offset;
    logic          wr_full, almost_full, half_full;
    logic [DW-1:0] rd_data;
    logic          rd_drv, rd_empty, almost_empty;
    int            checks = 0, failures = 0;

    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.5;
        forever begin rd_clk = ~rd_clk; #2.5; end
    end

    dc_fifo_rt #(.DW(DW), .AW(AW)) i_dc_fifo_rt (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .af_offset(af_offset), .wr_full(wr_full), .almost_full(almost_full),
        .half_full(half_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .fwft_mode(fwft_mode), .rd_en(rd_en), .rd_oe(rd_oe), .retx(retx),
        .ae_offset(ae_offset), .rd_data(rd_data), .rd_drv(rd_drv),
        .rd_empty(rd_empty), .almost_empty(almost_empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic m);
        wr_rst_n = 1'b0; rd_rst_n = 1'b0; fwft_mode = m;
        wr_en = 1'b0; rd_en = 1'b0; retx = 1'b0; rd_oe = 1'b1;
        repeat (3) @(negedge wr_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge rd_clk);
    endtask

    task automatic push_burst(input int n, input logic [8:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b1; wr_data = 9'(seed + 9'(i));
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic std_read(input string tag, input logic [8:0] exp);
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic fw_read(input string tag, input logic [8:0] exp);
        chk({tag, " ready"}, 32'(rd_empty), 32'd0);
        chk(tag, 32'(rd_data), 32'(exp));
        rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge wr_clk);
        failures++;
        $display("FAIL R12 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        af_offset = 4'd3; ae_offset = 4'd2; wr_data = '0;

        // R2: reset state
        do_reset(1'b0);
        chk("R2 rd_empty", 32'(rd_empty), 1);
        chk("R2 wr_full", 32'(wr_full), 0);
        chk("R2 almost_empty", 32'(almost_empty), 1);
        chk("R2 almost_full", 32'(almost_full), 0);
        chk("R2 half_full", 32'(half_full), 0);
        chk("R2 rd_data", 32'(rd_data), 0);

        // Table walk: R1 mode latched, R3/R5 order, R4 capacity, R6/R7 flags
        foreach (VECS[v]) begin
            do_reset(VECS[v].fw);
            fwft_mode = ~VECS[v].fw;   // R1: must be ignored after reset
            push_burst(int'(VECS[v].cnt), VECS[v].seed);
            settle();
            chk("R4 wr_full", 32'(wr_full), 32'(VECS[v].full));
            chk("R7 half_full", 32'(half_full), 32'(VECS[v].half));
            chk("R7 almost_full", 32'(almost_full), 32'(VECS[v].af));
            chk("R6 almost_empty", 32'(almost_empty), 32'(VECS[v].ae));
            chk("R1 rd_empty after fill", 32'(rd_empty), 0);
            for (int i = 0; i < int'(VECS[v].nread); i++) begin
                if (VECS[v].fw) fw_read("R5 fwft data", 9'(VECS[v].seed + 9'(i)));
                else            std_read("R3 std data", 9'(VECS[v].seed + 9'(i)));
            end
            settle();
            chk("R4 R5 empty after drain", 32'(rd_empty), 1);
        end

        // R3: read while empty is ignored; R12: two read edges of sync delay
        do_reset(1'b0);
        std_read("R3 empty read ignored", 9'h000);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = 9'h1AB;
        @(negedge wr_clk); wr_en = 1'b0;
        begin
            int n = 0;
            do begin
                @(negedge rd_clk); n++;
            end while (rd_empty && n < 10);
            chk("R12 sync edges", 32'(n), 2);
        end
        std_read("R3 word after empty read", 9'h1AB);

        // R8/R10: standard retransmit
        do_reset(1'b0);
        push_burst(10, 9'h100);
        settle();
        for (int i = 0; i < 8; i++) std_read("R3 pre-retx data", 9'(9'h100 + 9'(i)));
        settle();
        chk("R10 ae before retx", 32'(almost_empty), 1);
        chk("R10 half before retx", 32'(half_full), 0);
        @(negedge rd_clk); retx = 1'b1;
        @(negedge rd_clk); retx = 1'b0;
        chk("R8 empty during setup", 32'(rd_empty), 1);
        @(negedge rd_clk);
        chk("R8 empty clears", 32'(rd_empty), 0);
        settle();
        chk("R10 ae after retx", 32'(almost_empty), 0);
        chk("R10 half after retx", 32'(half_full), 1);
        std_read("R8 first word replay", 9'h100);
        std_read("R8 second word replay", 9'h101);

        // R9: fall-through retransmit, then R11 output enable
        do_reset(1'b1);
        push_burst(4, 9'h040);
        settle();
        fw_read("R5 fwft data", 9'h040);
        fw_read("R5 fwft data", 9'h041);
        retx = 1'b1;
        @(negedge rd_clk); retx = 1'b0;
        chk("R9 not ready cycle 1", 32'(rd_empty), 1);
        @(negedge rd_clk);
        chk("R9 not ready cycle 2", 32'(rd_empty), 1);
        @(negedge rd_clk);
        chk("R9 ready cycle 3", 32'(rd_empty), 0);
        chk("R9 first word shown", 32'(rd_data), 32'h040);
        rd_oe = 1'b0;
        @(negedge rd_clk);
        chk("R11 data gated", 32'(rd_data), 0);
        chk("R11 drive low", 32'(rd_drv), 0);
        rd_oe = 1'b1;
        @(negedge rd_clk);
        chk("R11 drive high", 32'(rd_drv), 1);
        fw_read("R11 word kept", 9'h040);
        fw_read("R9 replay continues", 9'h041);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule